// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a very small 8-bit accumulator machine with a 6-bit address space. Each instruction is one byte. The top two bits select the operation and the low six bits give a memory address. The four operations are add-to-accumulator, AND-with-accumulator, jump and accumulator increment. The machine only reads from memory: it has no store path.

A hardwired control unit sequences the work. It holds a small state counter, decodes that counter into one line per state, and forms the register load, increment and clear strobes from those lines.

- **Registers.** An 8-bit accumulator, an 8-bit data register, a 6-bit program counter, a 6-bit address register and a 2-bit opcode register.
- **Shared bus.** The registers exchange values over one 8-bit internal bus. Only the program counter and the data register ever place a value on it.
- **Memory port.** The port presents an address and a read strobe. The memory must return the addressed byte in the same cycle, and the data register captures it at the next rising clock edge.
- **Observation.** The accumulator, the program counter and an instruction-boundary flag are brought out, so that a system can observe the results of execution.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `pc` = 0, `acc` = 0, `fetch_start` = 1 and `mem_rd` = 0.
- R2: Every instruction begins with three fetch cycles. In the first, `fetch_start` is 1. In the second, `mem_rd` is 1 with `mem_addr` equal to the program counter, and the program counter advances by one. In the third, the opcode (byte bits 7:6) and the address field (byte bits 5:0) are split off.
- R3: Opcode 00 reads the byte at the address field and sets `acc` to the 8-bit sum of `acc` and that byte, discarding the carry.
- R4: Opcode 01 reads the byte at the address field and sets `acc` to the bitwise AND of `acc` and that byte.
- R5: Opcode 10 loads the program counter with the address field, and `acc` is left unchanged.
- R6: Opcode 11 adds one to `acc` (0xFF becomes 0x00). Its address field has no effect, and it makes no memory read beyond the fetch.
- R7: Add and AND instructions take 5 clock cycles. Jump and increment take 4 clock cycles. Control then returns to the first fetch state.
- R8: The program counter wraps from 63 to 0 when it is incremented.
- R9: Opcode 00 and opcode 01 make exactly two memory reads per instruction: the fetch, then the operand read at the address field.
- R10: `acc` does not change during the fetch cycles or during a jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 6 | Memory read address (address register) |
| mem_rd | output | 1 | Memory read strobe; data is taken at the next rising edge |
| mem_rdata | input | 8 | Byte returned by memory for `mem_addr` |
| acc | output | 8 | Accumulator value |
| pc | output | 6 | Program counter value |
| fetch_start | output | 1 | High in the first fetch cycle of every instruction |

## Verification
The hardest case to reach from the ports is the program counter wrapping from 63 to 0. Reaching it requires a jump to the last few memory locations, followed by straight-line code that runs off the end of memory. The stimulus places such a jump early in the program and fills the top locations with increment instructions. Those increments also carry non-zero address fields, which shows that the address field is ignored. The counter is then checked as it returns to zero, and execution is shown to resume from location 0.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW  = 6,
  parameter int OPW = 2
) (
  input  logic                clk,
  input  logic                rst,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_rd,
  input  logic [AW+OPW-1:0]   mem_rdata,
  output logic [AW+OPW-1:0]   acc,
  output logic [AW-1:0]       pc,
  output logic                fetch_start
);
  localparam int DW = AW + OPW;
  localparam int SW = OPW + 2;
  localparam int NS = 1 << SW;

  localparam logic [SW-1:0] ST_F1   = SW'(0);
  localparam logic [SW-1:0] ST_F2   = SW'(1);
  localparam logic [SW-1:0] ST_F3   = SW'(2);
  localparam logic [SW-1:0] ST_ADD1 = SW'(8);
  localparam logic [SW-1:0] ST_ADD2 = SW'(9);
  localparam logic [SW-1:0] ST_AND1 = SW'(10);
  localparam logic [SW-1:0] ST_AND2 = SW'(11);
  localparam logic [SW-1:0] ST_JMP1 = SW'(12);
  localparam logic [SW-1:0] ST_INC1 = SW'(14);

  logic [SW-1:0]  st;
  logic [NS-1:0]  dec;
  logic [DW-1:0]  dr;
  logic [AW-1:0]  ar;
  logic [OPW-1:0] ir;
  logic [DW-1:0]  bus;
  logic [DW-1:0]  alu;

  assign dec = NS'(1) << st;

  wire s_f1   = dec[ST_F1];
  wire s_f2   = dec[ST_F2];
  wire s_f3   = dec[ST_F3];
  wire s_add1 = dec[ST_ADD1];
  wire s_add2 = dec[ST_ADD2];
  wire s_and1 = dec[ST_AND1];
  wire s_and2 = dec[ST_AND2];
  wire s_jmp1 = dec[ST_JMP1];
  wire s_inc1 = dec[ST_INC1];

  wire ctr_load = s_f3;
  wire ctr_clr  = s_add2 | s_and2 | s_jmp1 | s_inc1;

  wire pc_drv = s_f1;
  wire dr_drv = s_f3 | s_jmp1;

  wire ar_ld  = s_f1 | s_f3;
  wire ir_ld  = s_f3;
  wire pc_ld  = s_jmp1;
  wire pc_inc = s_f2;
  wire dr_ld  = s_f2 | s_add1 | s_and1;
  wire ac_ld  = s_add2 | s_and2;
  wire ac_inc = s_inc1;
  wire alu_and = s_and2;

  assign bus = pc_drv ? DW'(pc) : (dr_drv ? dr : '0);

  wire [DW-1:0] sum  = acc + dr;
  wire [DW-1:0] conj = acc & dr;
  assign alu = alu_and ? conj : sum;

  always_ff @(posedge clk) begin
    if (rst)           st <= ST_F1;
    else if (ctr_clr)  st <= ST_F1;
    else if (ctr_load) st <= {1'b1, bus[DW-1:AW], 1'b0};
    else               st <= st + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      acc <= '0;
      dr  <= '0;
      ar  <= '0;
      ir  <= '0;
    end else begin
      if (ar_ld)       ar <= bus[AW-1:0];
      if (ir_ld)       ir <= bus[DW-1:AW];
      if (dr_ld)       dr <= mem_rdata;
      if (pc_ld)       pc <= bus[AW-1:0];
      else if (pc_inc) pc <= pc + 1'b1;
      if (ac_ld)       acc <= alu;
      else if (ac_inc) acc <= acc + 1'b1;
    end
  end

  assign mem_addr    = ar;
  assign mem_rd      = dr_ld;
  assign fetch_start = s_f1;

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst) s_f1 |=> s_f2); // R2
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst) s_f2 |=> (s_f3 && pc == AW'($past(pc) + 1'b1))); // R2
  AST_EXEC_RETURN: assert property (@(posedge clk) disable iff (rst) ctr_clr |=> s_f1); // R7
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst) (s_f1 || s_f2 || s_f3 || s_jmp1) |=> $stable(acc)); // R10
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst) s_jmp1 |=> pc == $past(dr[AW-1:0])); // R5
  AST_BUS_OWNER: assert property (@(posedge clk) disable iff (rst) $countones({pc_drv, dr_drv}) <= 1); // R9
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] mem_addr;
  logic       mem_rd;
  logic [7:0] mem_rdata;
  logic [7:0] acc;
  logic [5:0] pc;
  logic       fetch_start;
  logic [7:0] mem [64];

  int n_chk  = 0;
  int n_fail = 0;
  int last_cycles;
  int last_reads;
  logic [5:0] last_opaddr;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  acc_cpu u_acc_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .acc(acc), .pc(pc), .fetch_start(fetch_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_instr();
    last_cycles = 0;
    last_reads  = 0;
    last_opaddr = '0;
    do begin
      @(negedge clk);
      last_cycles++;
      if (mem_rd) begin
        last_reads++;
        if (last_reads == 2) last_opaddr = mem_addr;
      end
    end while (!fetch_start && last_cycles < 20);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  task automatic t_reset();
    clear_mem();
    do_reset();
    chk("R1 pc", pc, 0);
    chk("R1 acc", acc, 0);
    chk("R1 fetch_start", fetch_start, 1);
    chk("R1 mem_rd", mem_rd, 0);
    @(negedge clk);
    chk("R2 fetch read strobe", mem_rd, 1);
    chk("R2 fetch address", mem_addr, 0);
  endtask

  task automatic t_arith();
    rst = 1'b1;
    clear_mem();
    mem[0] = 8'h20; mem[32] = 8'h25;
    mem[1] = 8'h21; mem[33] = 8'hF0;
    mem[2] = 8'h62; mem[34] = 8'h1C;
    mem[3] = 8'hFF;
    do_reset();
    run_instr();
    chk("R3 add acc", acc, 8'h25);
    chk("R7 add cycles", last_cycles, 5);
    chk("R9 add reads", last_reads, 2);
    chk("R9 add operand addr", last_opaddr, 32);
    chk("R2 pc after fetch", pc, 1);
    run_instr();
    chk("R3 add wrap acc", acc, 8'h15);
    run_instr();
    chk("R4 and acc", acc, 8'h14);
    chk("R7 and cycles", last_cycles, 5);
    chk("R9 and operand addr", last_opaddr, 34);
    run_instr();
    chk("R6 inc acc", acc, 8'h15);
    chk("R6 inc reads", last_reads, 1);
    chk("R7 inc cycles", last_cycles, 4);
  endtask

  task automatic t_jump_wrap();
    rst = 1'b1;
    clear_mem();
    mem[0] = 8'hBC;
    for (int i = 60; i < 64; i++) mem[i] = 8'hC0 | 8'(i);
    mem[32] = 8'h07;
    do_reset();
    run_instr();
    chk("R5 jmp pc", pc, 60);
    chk("R10 jmp acc", acc, 0);
    chk("R7 jmp cycles", last_cycles, 4);
    for (int i = 0; i < 3; i++) run_instr();
    chk("R8 pc before wrap", pc, 63);
    run_instr();
    chk("R8 pc wrap", pc, 0);
    chk("R6 inc ignores address", acc, 4);
  endtask

  task automatic t_inc_wrap();
    rst = 1'b1;
    clear_mem();
    mem[0] = 8'h30; mem[48] = 8'hFF;
    mem[1] = 8'hC5;
    mem[2] = 8'h70; mem[48] = 8'hFF;
    do_reset();
    run_instr();
    chk("R3 load ff", acc, 8'hFF);
    run_instr();
    chk("R6 inc wrap", acc, 8'h00);
    run_instr();
    chk("R4 and zero", acc, 8'h00);
    do_reset();
    chk("R1 reset mid run pc", pc, 0);
    chk("R1 reset mid run acc", acc, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_mem();
    t_reset();
    t_arith();
    t_jump_wrap();
    t_inc_wrap();
    finish_run();
  end
endmodule